// File: doc/BRIEF.md
# Bulk Transmit Packet Framer

The framer sits in the transmit path between an Ethernet frame source and a bulk endpoint. It takes one frame at a time as a byte stream over an AXI4-Stream slave. The frame's byte count travels on a side input that is valid with the first data beat. On the master side it sends a four-byte length word first. The frame bytes follow unchanged. When the framed size would end exactly on a short-packet boundary of the bulk pipe, a four-byte filler word is added at the end.

The length word holds the 16-bit length in its lower half and the one's complement of that length in its upper half. It is sent least significant byte first. The filler is needed when the length plus four is an exact multiple of one less than the bulk maximum packet size. A small bit-serial divider decides this while the header and the body are streaming. The maximum packet size is a configuration input. It is sampled together with the length.

Top module: `bulk_tx_framer`

## Requirements
- R1: Each output frame starts with four header bytes, in this order: len[7:0], len[15:8], ~len[7:0], ~len[15:8]. These are the bytes of the 32-bit word ((len ^ 16'hFFFF) << 16) + len, least significant byte first.
- R2: No frame byte is accepted before all four header bytes have been handed off. Exactly `len` frame bytes then pass through in order and unmodified. Each one is taken on the slave in the same cycle it is handed off on the master.
- R3: A pad of bytes 00, 00, FF, FF follows the frame when cfg_max_pkt > 1 and (len + 4) mod (cfg_max_pkt - 1) = 0. In all other cases no pad is added.
- R4: m_tlast is high on the final pad byte when a pad is present, and on the final frame byte otherwise. It is low on every other byte.
- R5: The length and cfg_max_pkt are sampled when the first beat is seen while the block is idle. Changes to cfg_max_pkt during a frame have no effect on that frame.
- R6: A new length is accepted only after the previous output has drained. m_tvalid is low for at least one cycle after a handoff with m_tlast, and s_tready is low outside the frame-body phase.
- R7: While m_tvalid is high and m_tready is low, m_tdata and m_tlast hold their values (given a compliant upstream).
- R8: During and right after reset, m_tvalid and s_tready are low.
- R9: A cfg_max_pkt of 0 or 1 never produces a pad.
- R10: For frames too short for the pad decision to be ready in time, the final frame byte is held back until the decision is known. The output is still exact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_max_pkt | input | MP_W (11) | Bulk maximum packet size in bytes |
| s_len | input | LEN_W (16) | Frame length in bytes (at least 1), valid with the first beat |
| s_tdata | input | 8 | Frame byte |
| s_tvalid | input | 1 | Frame byte valid |
| s_tready | output | 1 | Frame byte accepted |
| m_tdata | output | 8 | Framed output byte |
| m_tvalid | output | 1 | Output byte valid |
| m_tready | input | 1 | Downstream ready |
| m_tlast | output | 1 | Last byte of the framed transfer |

## Verification
The first header byte is offered one cycle after the edge at which the idle block sees s_tvalid. Each following byte is offered in the cycle after the previous handoff, so body bytes appear combinationally in their own handoff cycle. The pad decision is ready seventeen cycles after capture. This stalls only the final byte of very short frames.

A scoreboard queue holds the expected bytes in order. The monitor compares only at handoffs, sampled at the falling edge once all inputs have settled. Because of this, stalls from the divider, from random backpressure and from upstream gaps cannot shift the comparison. The idle gap after each m_tlast is checked at the falling edge that follows the handoff.

// File: rtl/bulk_tx_framer.sv
module bulk_tx_framer #(
  parameter int LEN_W = 16,
  parameter int MP_W  = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MP_W-1:0]  cfg_max_pkt,
  input  logic [LEN_W-1:0] s_len,
  input  logic [7:0]       s_tdata,
  input  logic             s_tvalid,
  output logic             s_tready,
  output logic [7:0]       m_tdata,
  output logic             m_tvalid,
  input  logic             m_tready,
  output logic             m_tlast
);
  localparam int NB = LEN_W + 1;
  localparam int CW = $clog2(NB + 1);

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_BODY, S_PAD} st_t;

  st_t              st;
  logic [1:0]       idx;
  logic [LEN_W-1:0] len_q, left_q;
  logic [MP_W-1:0]  div_q, rem_q;
  logic             no_pad_q;
  logic [NB-1:0]    num_q;
  logic [CW-1:0]    dcnt;

  wire capture   = (st == S_IDLE) && s_tvalid;
  wire div_done  = (dcnt == '0);
  wire pad_need  = !no_pad_q && (rem_q == '0);
  wire [15:0] l16 = 16'(len_q);
  wire [MP_W:0] shl = {rem_q, num_q[NB-1]};
  wire fits      = shl >= {1'b0, div_q};
  wire body_last = (left_q == LEN_W'(1));
  wire body_ok   = !body_last || div_done;
  wire fire      = m_tvalid && m_tready;

  assign s_tready = (st == S_BODY) && m_tready && body_ok;

  always_comb begin
    m_tvalid = 1'b0;
    m_tdata  = 8'h00;
    m_tlast  = 1'b0;
    case (st)
      S_HDR: begin
        m_tvalid = 1'b1;
        case (idx)
          2'd0: m_tdata = l16[7:0];
          2'd1: m_tdata = l16[15:8];
          2'd2: m_tdata = ~l16[7:0];
          default: m_tdata = ~l16[15:8];
        endcase
      end
      S_BODY: begin
        m_tvalid = s_tvalid && body_ok;
        m_tdata  = s_tdata;
        m_tlast  = body_last && !pad_need;
      end
      S_PAD: begin
        m_tvalid = 1'b1;
        m_tdata  = idx[1] ? 8'hFF : 8'h00;
        m_tlast  = (idx == 2'd3);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      num_q    <= '0;
      rem_q    <= '0;
      dcnt     <= '0;
      div_q    <= '0;
      no_pad_q <= 1'b1;
    end else if (capture) begin
      num_q    <= NB'(s_len) + NB'(4);
      rem_q    <= '0;
      dcnt     <= CW'(NB);
      div_q    <= cfg_max_pkt - MP_W'(1);
      no_pad_q <= (cfg_max_pkt <= MP_W'(1));
    end else if (!div_done) begin
      rem_q <= fits ? MP_W'(shl - {1'b0, div_q}) : MP_W'(shl);
      num_q <= num_q << 1;
      dcnt  <= dcnt - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      idx    <= '0;
      len_q  <= '0;
      left_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (capture) begin
          len_q  <= s_len;
          left_q <= s_len;
          idx    <= '0;
          st     <= S_HDR;
        end
        S_HDR: if (fire) begin
          idx <= idx + 2'd1;
          if (idx == 2'd3) st <= S_BODY;
        end
        S_BODY: if (fire) begin
          left_q <= left_q - LEN_W'(1);
          if (body_last) begin
            idx <= '0;
            st  <= pad_need ? S_PAD : S_IDLE;
          end
        end
        default: if (fire) begin
          idx <= idx + 2'd1;
          if (idx == 2'd3) st <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/bulk_tx_framer_chk.sv
module bulk_tx_framer_chk #(
  parameter int LEN_W = 16,
  parameter int MP_W  = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic [MP_W-1:0]  cfg_max_pkt,
  input logic [LEN_W-1:0] s_len,
  input logic [7:0]       s_tdata,
  input logic             s_tvalid,
  input logic             s_tready,
  input logic [7:0]       m_tdata,
  input logic             m_tvalid,
  input logic             m_tready,
  input logic             m_tlast
);
  logic [2:0] beats;
  logic [7:0] b0;
  wire fire = m_tvalid && m_tready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beats <= '0;
      b0    <= '0;
    end else if (fire) begin
      if (beats == 3'd0) b0 <= m_tdata;
      if (m_tlast) beats <= '0;
      else if (beats < 3'd4) beats <= beats + 3'd1;
    end
  end

  AST_HDR_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
    fire && beats == 3'd2 |-> m_tdata == ~b0); // R1
  AST_HDR_BEFORE_BODY: assert property (@(posedge clk) disable iff (!rst_n)
    s_tvalid && s_tready |-> beats == 3'd4); // R2
  AST_BODY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    s_tvalid && s_tready |-> fire && m_tdata == s_tdata); // R2
  AST_NO_LAST_IN_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    fire && beats < 3'd4 |-> !m_tlast); // R4
  AST_IDLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    fire && m_tlast |=> !m_tvalid); // R6
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tlast)); // R7
endmodule

bind bulk_tx_framer bulk_tx_framer_chk #(.LEN_W(LEN_W), .MP_W(MP_W)) u_chk (.*);

// File: tb/bulk_tx_framer_tb.sv
module bulk_tx_framer_tb;
  localparam int CLK_P = 10;
  localparam int LEN_W = 16;
  localparam int MP_W  = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [MP_W-1:0]  cfg_max_pkt = '0;
  logic [LEN_W-1:0] s_len = '0;
  logic [7:0] s_tdata = '0;
  logic s_tvalid = 1'b0;
  logic s_tready;
  logic [7:0] m_tdata;
  logic m_tvalid;
  logic m_tready = 1'b1;
  logic m_tlast;

  int n_chk = 0;
  int n_bad = 0;
  bit bp_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  logic [7:0] exp_d[$];
  logic       exp_l[$];
  string      exp_r[$];

  always #(CLK_P/2) clk = ~clk;

  bulk_tx_framer #(.LEN_W(LEN_W), .MP_W(MP_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_max_pkt(cfg_max_pkt), .s_len(s_len),
    .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tlast(m_tlast));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic l, input string r);
    exp_d.push_back(d);
    exp_l.push_back(l);
    exp_r.push_back(r);
  endtask

  task automatic send_frame(input int len, input int mp, input bit gaps);
    bit pad;
    logic [15:0] l16;
    pad = (mp > 1) && (((len + 4) % (mp - 1)) == 0);
    l16 = 16'(len);
    push(l16[7:0], 1'b0, "R1");
    push(l16[15:8], 1'b0, "R1");
    push(~l16[7:0], 1'b0, "R1");
    push(~l16[15:8], 1'b0, "R1");
    for (int i = 0; i < len; i++)
      push(8'((i * 13 + len) & 255), (i == len - 1) && !pad, (i == len - 1) ? "R4" : "R2");
    if (pad) begin
      push(8'h00, 1'b0, "R3");
      push(8'h00, 1'b0, "R3");
      push(8'hFF, 1'b0, "R3");
      push(8'hFF, 1'b1, "R3");
    end
    cfg_max_pkt = MP_W'(mp);
    s_len = LEN_W'(len);
    for (int i = 0; i < len; i++) begin
      s_tdata  = 8'((i * 13 + len) & 255);
      s_tvalid = 1'b1;
      forever begin
        @(negedge clk);
        if (s_tready) break;
      end
      @(posedge clk); #1;
      if (i == 0) cfg_max_pkt = MP_W'(mp) ^ 11'h155; // R5: late change must be ignored
      if (gaps && (i % 3 == 1)) begin
        s_tvalid = 1'b0;
        @(posedge clk); #1;
      end
    end
    s_tvalid = 1'b0;
  endtask

  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    m_tready <= bp_en ? (lfsr[0] | lfsr[3]) : 1'b1;
  end

  initial begin : monitor
    bit after_last;
    after_last = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (after_last) check(!m_tvalid, "R6", m_tvalid, 0);
        after_last = 1'b0;
        if (m_tvalid && m_tready) begin
          if (exp_d.size() == 0) begin
            check(1'b0, "R2", m_tdata, -1);
          end else begin
            logic [7:0] ed;
            logic el;
            string er;
            ed = exp_d.pop_front();
            el = exp_l.pop_front();
            er = exp_r.pop_front();
            check(m_tdata == ed, er, m_tdata, ed);
            check(m_tlast == el, "R4", m_tlast, el);
          end
          after_last = m_tlast;
        end
      end
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!m_tvalid, "R8", m_tvalid, 0);
    check(!s_tready, "R8", s_tready, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(!m_tvalid && !s_tready, "R8", {m_tvalid, s_tready}, 0);
    @(posedge clk); #1;
    send_frame(60, 512, 1'b0);
    send_frame(507, 512, 1'b0);    // R3: 511 % 511 = 0
    send_frame(508, 513, 1'b1);    // R3: 512 % 512 = 0
    send_frame(1, 6, 1'b0);        // R10 short, pad
    send_frame(2, 4, 1'b0);        // R10 short, pad
    send_frame(3, 2, 1'b0);        // R10 divisor 1 always pads
    send_frame(10, 1, 1'b0);       // R9
    send_frame(5, 0, 1'b0);        // R9
    send_frame(300, 64, 1'b1);
    bp_en = 1'b1;                  // R7 under backpressure
    send_frame(59, 64, 1'b1);
    send_frame(1000, 65, 1'b0);
    send_frame(2042, 2047, 1'b1);
    send_frame(1, 3, 1'b0);        // R10
    bp_en = 1'b0;
    send_frame(4660, 512, 1'b0);   // R1 high length byte
    while (exp_d.size() != 0) @(posedge clk);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(!m_tvalid && !s_tready, "R6", {m_tvalid, s_tready}, 0);
    check(exp_d.size() == 0, "R2", exp_d.size(), 0);
    finish_run();
  end
endmodule